// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Global Gate

The block merges six level-sensitive interrupt requests into one host interrupt line. The sources are two I2C controllers, one SPI controller, two DMA channels and a common-interface controller. Each source has its own mask bit. Software never writes the mask directly. It writes ones to a set alias to turn sources on, or to a clear alias to turn them off. Bits written as zero leave their sources unchanged.

A second level of gating sits above the masks. A single global enable bit closes or opens the host line without altering any mask. A service routine can therefore silence the line while it works and reopen it afterwards. If a source is still unmasked and active, reopening raises the line again.

Software can read two status views:
- The raw source levels, regardless of mask.
- The state of the host line itself.

Sources clear only when they are serviced at their origin, so no register in this block is write-to-clear.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all mask bits and the global enable are zero and `irq_out` is low. Enabling the gate alone, with every source active, leaves the line low.
- R2: A read at offset 0x20 returns the live source levels in bits [5:0], whatever the mask. The bit positions are I2C0=0, I2C1=1, SPI=2, DMA0=3, DMA1=4 and common interface=5. Bits [15:6] read as zero.
- R3: Writing to offset 0x24 sets each mask bit whose data bit is one. Mask bits written as zero keep their value.
- R4: Writing to offset 0x28 clears each mask bit whose data bit is one. Mask bits written as zero keep their value.
- R5: Writing 0xFFFF to offset 0x28 disables every source in one write.
- R6: Offset 0x50 holds the global enable in bit 7. A write loads that bit, and a read returns it in bit 7.
- R7: `irq_out` is registered. It equals the OR over sources of (source AND mask), ANDed with the global enable, using the inputs present at the previous rising edge.
- R8: Writing zero to bit 7 at offset 0x50 drops `irq_out` in the cycle after the write, even while unmasked sources stay active. Writing bit 7 again raises the line in the cycle after that write if any unmasked source is still active.
- R9: A read at offset 0x40 returns the current state of `irq_out` in bit 7, with all other bits zero.
- R10: Writes to any offset other than 0x24, 0x28 and 0x50 have no effect. Data bits above the six source positions have no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Level interrupt requests, one per source |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Gated host interrupt line |

## Verification
The bench uses several kinds of stimulus:
- A source vector that is all ones while the masks are still at their reset value. This separates the mask gate from the global gate.
- Source patterns that lie wholly inside the set mask, and patterns that lie wholly outside it. These show that set and clear writes touch only the selected bits.
- A pending source held steady across a close and a reopen of the global enable. This shows that the line drops with the masks untouched and returns when the gate reopens.
- Random mixes of writes to all offsets, including unused ones and wide data, under random source levels. These compare the line and both status views cycle by cycle against a bench model.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    // Register byte offsets
    localparam int unsigned OFS_RAW   = 32'h20;
    localparam int unsigned OFS_MSET  = 32'h24;
    localparam int unsigned OFS_MCLR  = 32'h28;
    localparam int unsigned OFS_BSTAT = 32'h40;
    localparam int unsigned OFS_BEN   = 32'h50;

    // Bit position of the gate / line flag inside the bridge registers
    localparam int unsigned GATE_BIT = 7;

    // Source bit positions in the status and mask space
    typedef enum int unsigned {
        SRC_I2C0 = 0,
        SRC_I2C1 = 1,
        SRC_SPI  = 2,
        SRC_DMA0 = 3,
        SRC_DMA1 = 4,
        SRC_CI   = 5
    } src_idx_e;
endpackage

// File: rtl/irqagg_decode.sv
`timescale 1ns/1ps
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] set_vec,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic              en_wr,
    output logic              en_val
);
    logic hit_set, hit_clr, hit_en;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        hit_set = bus_wr && (bus_addr == ADDR_W'(OFS_MSET));
        hit_clr = bus_wr && (bus_addr == ADDR_W'(OFS_MCLR));
        hit_en  = bus_wr && (bus_addr == ADDR_W'(OFS_BEN));
        set_vec = hit_set ? bus_wdata[NUM_SRC-1:0] : '0;
        clr_vec = hit_clr ? bus_wdata[NUM_SRC-1:0] : '0;
        en_wr   = hit_en;
        en_val  = bus_wdata[GATE_BIT];
    end
endmodule

// File: rtl/irqagg_mask.sv
`timescale 1ns/1ps
module irqagg_mask #(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] mask_d,
    output logic [NUM_SRC-1:0] mask_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic [NUM_SRC-1:0] bit_nxt;

    // Per-source next value: clear wins, then set, else hold
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        assign bit_nxt[i] = clr_vec[i] ? 1'b0 :
                            set_vec[i] ? 1'b1 : st_q.bits[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = bit_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_d = st_d.bits;
    assign mask_q = st_q.bits;
endmodule

// File: rtl/irqagg_gate.sv
`timescale 1ns/1ps
module irqagg_gate #(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [NUM_SRC-1:0] mask_nxt,
    input  logic               en_wr,
    input  logic               en_val,
    output logic               en_q,
    output logic               line_q
);
    typedef struct packed {
        logic en;
        logic line;
    } gate_st_t;

    gate_st_t st_d, st_q;

    // Line uses the post-write enable and mask so a gate close acts at once
    always_comb begin
        st_d = st_q;
        if (en_wr) st_d.en = en_val;
        st_d.line = st_d.en && (|(src_irq & mask_nxt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign line_q = st_q.line;
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] set_vec, clr_vec;
    logic [NUM_SRC-1:0] mask_d, mask_q;
    logic               en_wr, en_val, en_q, irq_q;

    irqagg_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .en_wr     (en_wr),
        .en_val    (en_val)
    );

    irqagg_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask_d  (mask_d),
        .mask_q  (mask_q)
    );

    irqagg_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_irq  (src_irq),
        .mask_nxt (mask_d),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .en_q     (en_q),
        .line_q   (irq_q)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_RAW))   bus_rdata[NUM_SRC-1:0] = src_irq;
        if (bus_addr == ADDR_W'(OFS_BSTAT)) bus_rdata[GATE_BIT]    = irq_q;
        if (bus_addr == ADDR_W'(OFS_BEN))   bus_rdata[GATE_BIT]    = en_q;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_irq,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               en_q
);
    logic [NUM_SRC-1:0] wlow;
    logic wr_set, wr_clr, wr_en;
    logic unused_chk;

    assign wlow   = bus_wdata[NUM_SRC-1:0];
    assign wr_set = bus_wr && (bus_addr == ADDR_W'(OFS_MSET));
    assign wr_clr = bus_wr && (bus_addr == ADDR_W'(OFS_MCLR));
    assign wr_en  = bus_wr && (bus_addr == ADDR_W'(OFS_BEN));
    assign unused_chk = ^bus_wdata;

    assert_line_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q && (|($past(src_irq) & mask_q))));

    assert_gate_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_wdata[GATE_BIT]) |=> !irq_out);

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && (&wlow)) |=> (mask_q == '0));

    assert_set_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (((mask_q & $past(wlow)) == $past(wlow)) &&
                    ((mask_q & ~$past(wlow)) == ($past(mask_q) & ~$past(wlow)))));

    assert_clear_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (((mask_q & $past(wlow)) == '0) &&
                    ((mask_q & ~$past(wlow)) == ($past(mask_q) & ~$past(wlow)))));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(mask_q));
endmodule

bind irq_aggregator irqagg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_irq   (src_irq),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .en_q      (en_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    localparam int NS = 6;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [NS-1:0] m_mask = '0;
    logic          m_en = 1'b0;
    logic          m_line = 1'b0;

    always #2 clk = ~clk;

    irq_aggregator #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic exp_line(input logic [NS-1:0] s, input logic [NS-1:0] m, input logic e);
        return e && (|(s & m));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NS-1:0] s, input string tag);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_irq = s;
        @(posedge clk);
        if (wr) begin
            case (a)
                8'h24: m_mask = m_mask | d[NS-1:0];
                8'h28: m_mask = m_mask & ~d[NS-1:0];
                8'h50: m_en   = d[7];
                default: ;
            endcase
        end
        m_line = exp_line(s, m_mask, m_en);
        @(negedge clk);
        bus_wr = 1'b0;
        chk(tag, {31'b0, irq_out}, {31'b0, m_line});
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, {16'b0, bus_rdata}, {16'b0, exp});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 line in reset", {31'b0, irq_out}, 32'd0);
        rst_n = 1'b1;
        rd(8'h50, 16'h0000, "R1 enable reset");
        rd(8'h40, 16'h0000, "R1 status reset");
        // R1: gate on, all sources active, masks zero -> low
        cyc(1, 8'h50, 16'h0080, 6'h3F, "R1 masks zero");
        rd(8'h50, 16'h0080, "R6 enable readback");
        // R2: raw status ignores mask
        src_irq = 6'h15; rd(8'h20, 16'h0015, "R2 raw a");
        src_irq = 6'h2A; rd(8'h20, 16'h002A, "R2 raw b");
        // R3: set only selected bits
        cyc(1, 8'h24, 16'h0005, 6'h3F, "R3 set");
        rd(8'h40, 16'h0080, "R9 line high");
        cyc(0, 8'h00, 16'h0000, 6'h3A, "R3 unselected off");
        cyc(0, 8'h00, 16'h0000, 6'h04, "R3 SPI selected");
        // R4: clear selected
        cyc(1, 8'h24, 16'h003F, 6'h00, "R3 set all");
        cyc(1, 8'h28, 16'h0001, 6'h01, "R4 clear I2C0");
        cyc(0, 8'h00, 16'h0000, 6'h02, "R4 I2C1 kept");
        // R7: one-cycle latency
        cyc(0, 8'h00, 16'h0000, 6'h00, "R7 idle");
        src_irq = 6'h08; bus_addr = 8'h00; #1;
        chk("R7 before edge", {31'b0, irq_out}, 32'd0);
        cyc(0, 8'h00, 16'h0000, 6'h08, "R7 after edge");
        // R8: gate close with pending source, then reopen
        cyc(1, 8'h50, 16'h0000, 6'h08, "R8 close");
        rd(8'h40, 16'h0000, "R9 line low");
        rd(8'h50, 16'h0000, "R6 enable cleared");
        cyc(0, 8'h00, 16'h0000, 6'h08, "R8 stays closed");
        cyc(1, 8'h50, 16'h0080, 6'h08, "R8 reopen");
        // R10: writes elsewhere ignored
        cyc(1, 8'h40, 16'h0000, 6'h08, "R10 status write");
        cyc(1, 8'h30, 16'hFFFF, 6'h08, "R10 stray write");
        cyc(1, 8'h20, 16'h0000, 6'h08, "R10 raw write");
        // R5: clear all at once
        cyc(1, 8'h28, 16'hFFFF, 6'h3F, "R5 clear all");
        cyc(1, 8'h24, 16'hFFC0, 6'h3F, "R10 upper bits");
        rd(8'h20, 16'h003F, "R2 upper zero");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            int sel;
            sel = $urandom_range(0, 6);
            case (sel)
                0: a = 8'h24;
                1: a = 8'h28;
                2: a = 8'h50;
                3: a = 8'h40;
                4: a = 8'h20;
                5: a = 8'h33;
                default: a = 8'h24;
            endcase
            cyc(1'($urandom_range(0, 1)), a, 16'($urandom), 6'($urandom), "R7 random");
            if ((i % 4) == 0) begin
                rd(8'h20, {10'b0, src_irq}, "R2 random raw");
                rd(8'h40, {8'b0, m_line, 7'b0}, "R9 random status");
                rd(8'h50, {8'b0, m_en, 7'b0}, "R6 random enable");
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule